// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block turns one high-level NAND operation request into the series of latch cycles that an asynchronous NAND device expects on its shared 8-bit bus. The request carries:

- an opcode;
- an optional column and an optional page address;
- a flag saying the device is larger than 128 MB;
- a flag for a 16-bit data bus;
- a wait time in microseconds.

The sequencer emits one bus cycle per clock while a cycle is pending. Each cycle is a byte qualified by command-latch, address-latch and chip-enable outputs. A separate read strobe marks status-byte reads.

After the latch cycles, the opcode decides what happens next:

- **Erase and program opcodes** finish at once.
- **Page read** adds a read-start confirm cycle, then waits.
- **Reset** waits, then issues a status command and polls status until the device is ready.
- **Every other opcode** just waits.

The wait is counted in pulses of an external microsecond tick. A single-clock `done` pulse closes each operation. A new request is taken only while the block is idle.

Top module: `nand_cmd_seq`

## Requirements
- R1: A request is captured only when `reqValid` is high while `busy` is low. A request raised while `busy` is high has no effect on the running sequence. `busy` stays high from acceptance until `done`, and `done` is high for exactly one clock per operation.
- R2: The first bus cycle of every operation carries the opcode, with `busCle` and `busCe` high and `busAle` low.
- R3: When `reqHasCol` is set, two address cycles (`busAle` high) follow the opcode. The first carries bits 7:0 of the column and the second bits 15:8. When `reqWide16` is set, the column is shifted right by one bit before it is split.
- R4: When `reqHasPage` is set, address cycles carry page bits 7:0 and then 15:8. A third cycle carrying bits 23:16 follows only when `reqBig` is set. Page cycles come after any column cycles.
- R5: The clock after the last command or address cycle has `busCe` high, with `busCle`, `busAle` and `busValid` low.
- R6: For opcodes 0x60, 0xD0, 0x80 and 0x10, `done` rises exactly two clocks after the last bus cycle, with no wait.
- R7: For opcode 0x00, a confirm cycle with byte 0x30 and `busCle` high follows the release clock. After it, the block waits `reqDelayUs` ticks before `done`.
- R8: For opcode 0xFF, the block waits `reqDelayUs` ticks, then issues a status cycle with byte 0x70 and `busCle` high. It then asserts `busRead` once per clock until a sampled `statusByte` has bit 6 set, with no timeout. `done` follows that read.
- R9: For any opcode not named in R6 to R8, the block waits `reqDelayUs` ticks after the release clock and then raises `done`. A wait of zero ticks ends at once.
- R10: `busCle` and `busAle` are never high together. `busCe` is low whenever the block is idle, including the clock after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-clock pulse per microsecond |
| reqValid | input | 1 | Request strobe, taken while idle |
| reqOpcode | input | 8 | Command opcode |
| reqHasCol | input | 1 | Column present |
| reqColumn | input | 16 | Column address |
| reqHasPage | input | 1 | Page address present |
| reqPage | input | 24 | Page address |
| reqBig | input | 1 | Device larger than 128 MB (third page cycle) |
| reqWide16 | input | 1 | 16-bit data bus (column halved) |
| reqDelayUs | input | 16 | Post-command wait in ticks |
| statusByte | input | 8 | Status byte from the device, sampled while busRead is high |
| busy | output | 1 | Operation in progress |
| busValid | output | 1 | A write cycle is on the bus this clock |
| busData | output | 8 | Byte of the current write cycle |
| busCle | output | 1 | Command latch qualifier |
| busAle | output | 1 | Address latch qualifier |
| busCe | output | 1 | Chip enable |
| busRead | output | 1 | Status read cycle this clock |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench goes after the following corner cases.

- **Address-cycle count.** Column-only, page-only, both and neither requests, with the capacity flag on and off. A design that miscounted would add or drop an address byte, and the event list would differ.
- **Column halving.** A wide-bus request with an odd column exposes missing or misplaced halving.
- **Zero wait and polling.** Zero-tick waits and reset polls that need from one to five reads expose an off-by-one exit or a test of the wrong status bit. The default status byte has every bit set except bit 6.
- **Requests while busy.** A request raised mid-operation shows a design that accepts while busy: the opcode would reappear in the sequence.
- **Erase/program timing.** Erase and program opcodes catch a design that waits, because the cycle gap before `done` would grow.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam logic [7:0] OP_READ      = 8'h00;
  localparam logic [7:0] OP_READSTART = 8'h30;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_RESET     = 8'hFF;
  localparam logic [7:0] OP_ERASE1    = 8'h60;
  localparam logic [7:0] OP_ERASE2    = 8'hD0;
  localparam logic [7:0] OP_SEQIN     = 8'h80;
  localparam logic [7:0] OP_PROG      = 8'h10;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_COL0, ST_COL1, ST_PG0, ST_PG1, ST_PG2,
    ST_REL, ST_CONF, ST_WAIT, ST_STAT, ST_POLL, ST_DONE
  } seqState_e;

  typedef enum logic [2:0] {
    SEL_OP, SEL_COL0, SEL_COL1, SEL_PG0, SEL_PG1, SEL_PG2, SEL_CONF, SEL_STAT
  } byteSel_e;

  typedef struct packed {
    logic     loadReq;
    logic     loadDly;
    logic     countEn;
    byteSel_e sel;
  } seqStrb_t;
endpackage

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int COL_W = 16,
  parameter int PAGE_W = 24,
  parameter int DLY_W = 16,
  parameter int READY_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrb_t          strb,
  input  logic              usTick,
  input  logic [7:0]        reqOpcode,
  input  logic              reqHasCol,
  input  logic [COL_W-1:0]  reqColumn,
  input  logic              reqHasPage,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic              reqBig,
  input  logic              reqWide16,
  input  logic [DLY_W-1:0]  reqDelayUs,
  input  logic [7:0]        statusByte,
  output logic [7:0]        busData,
  output logic              hasCol,
  output logic              hasPage,
  output logic              isBig,
  output logic              isNoWait,
  output logic              isRead,
  output logic              isReset,
  output logic              dlyZero,
  output logic              devReady
);
  localparam logic [7:0] READY_MASK = 8'(1 << READY_BIT);

  logic [7:0]        opR;
  logic [COL_W-1:0]  colR;
  logic [PAGE_W-1:0] pgR;
  logic [DLY_W-1:0]  delR;
  logic [DLY_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR <= '0; colR <= '0; pgR <= '0; delR <= '0;
      hasCol <= 1'b0; hasPage <= 1'b0; isBig <= 1'b0;
    end else if (strb.loadReq) begin
      opR     <= reqOpcode;
      colR    <= reqWide16 ? (reqColumn >> 1) : reqColumn;
      pgR     <= reqPage;
      delR    <= reqDelayUs;
      hasCol  <= reqHasCol;
      hasPage <= reqHasPage;
      isBig   <= reqBig;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (strb.loadDly) cnt <= delR;
    else if (strb.countEn && usTick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign dlyZero  = (cnt == '0);
  assign devReady = |(statusByte & READY_MASK);
  assign isRead   = (opR == OP_READ);
  assign isReset  = (opR == OP_RESET);
  assign isNoWait = (opR == OP_ERASE1) || (opR == OP_ERASE2) ||
                    (opR == OP_SEQIN) || (opR == OP_PROG);

  always_comb begin
    unique case (strb.sel)
      SEL_OP:   busData = opR;
      SEL_COL0: busData = colR[7:0];
      SEL_COL1: busData = colR[15:8];
      SEL_PG0:  busData = pgR[7:0];
      SEL_PG1:  busData = pgR[15:8];
      SEL_PG2:  busData = pgR[23:16];
      SEL_CONF: busData = OP_READSTART;
      SEL_STAT: busData = OP_STATUS;
      default:  busData = opR;
    endcase
  end

  // R9
  dly_monotonic_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && !strb.loadDly) |=> (cnt <= $past(cnt)));
  // R1
  capture_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadReq |=> $stable(opR));
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     hasCol,
  input  logic     hasPage,
  input  logic     isBig,
  input  logic     isNoWait,
  input  logic     isRead,
  input  logic     isReset,
  input  logic     dlyZero,
  input  logic     devReady,
  output seqStrb_t strb,
  output logic     busy,
  output logic     busValid,
  output logic     busCle,
  output logic     busAle,
  output logic     busCe,
  output logic     busRead,
  output logic     done
);
  seqState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb = '{loadReq: 1'b0, loadDly: 1'b0, countEn: 1'b0, sel: SEL_OP};
    busValid = 1'b0; busCle = 1'b0; busAle = 1'b0; busRead = 1'b0; done = 1'b0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strb.loadReq = 1'b1;
        nextState = ST_CMD;
      end
      ST_CMD: begin
        busValid = 1'b1; busCle = 1'b1;
        nextState = hasCol ? ST_COL0 : (hasPage ? ST_PG0 : ST_REL);
      end
      ST_COL0: begin
        busValid = 1'b1; busAle = 1'b1; strb.sel = SEL_COL0;
        nextState = ST_COL1;
      end
      ST_COL1: begin
        busValid = 1'b1; busAle = 1'b1; strb.sel = SEL_COL1;
        nextState = hasPage ? ST_PG0 : ST_REL;
      end
      ST_PG0: begin
        busValid = 1'b1; busAle = 1'b1; strb.sel = SEL_PG0;
        nextState = ST_PG1;
      end
      ST_PG1: begin
        busValid = 1'b1; busAle = 1'b1; strb.sel = SEL_PG1;
        nextState = isBig ? ST_PG2 : ST_REL;
      end
      ST_PG2: begin
        busValid = 1'b1; busAle = 1'b1; strb.sel = SEL_PG2;
        nextState = ST_REL;
      end
      ST_REL: begin
        if (isNoWait) nextState = ST_DONE;
        else if (isRead) nextState = ST_CONF;
        else begin
          strb.loadDly = 1'b1;
          nextState = ST_WAIT;
        end
      end
      ST_CONF: begin
        busValid = 1'b1; busCle = 1'b1; strb.sel = SEL_CONF;
        strb.loadDly = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: begin
        strb.countEn = 1'b1;
        if (dlyZero) nextState = isReset ? ST_STAT : ST_DONE;
      end
      ST_STAT: begin
        busValid = 1'b1; busCle = 1'b1; strb.sel = SEL_STAT;
        nextState = ST_POLL;
      end
      ST_POLL: begin
        busRead = 1'b1;
        if (devReady) nextState = ST_DONE;
      end
      ST_DONE: begin
        done = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy  = (state != ST_IDLE);
  assign busCe = busy;

  // R10
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busCle && busAle));
  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R10
  ce_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busCe);
  // R1
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);
  // R8
  poll_qual_chk: assert property (@(posedge clk) disable iff (!rstN)
    busRead |-> (!busCle && !busAle && !busValid));
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int COL_W = 16,
  parameter int PAGE_W = 24,
  parameter int DLY_W = 16,
  parameter int READY_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              reqValid,
  input  logic [7:0]        reqOpcode,
  input  logic              reqHasCol,
  input  logic [COL_W-1:0]  reqColumn,
  input  logic              reqHasPage,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic              reqBig,
  input  logic              reqWide16,
  input  logic [DLY_W-1:0]  reqDelayUs,
  input  logic [7:0]        statusByte,
  output logic              busy,
  output logic              busValid,
  output logic [7:0]        busData,
  output logic              busCle,
  output logic              busAle,
  output logic              busCe,
  output logic              busRead,
  output logic              done
);
  seqStrb_t strb;
  logic hasCol, hasPage, isBig, isNoWait, isRead, isReset, dlyZero, devReady;

  nand_seq_ctrl u_ctrl (
    .clk, .rstN, .reqValid, .hasCol, .hasPage, .isBig, .isNoWait, .isRead,
    .isReset, .dlyZero, .devReady, .strb, .busy, .busValid, .busCle,
    .busAle, .busCe, .busRead, .done
  );

  nand_seq_dp #(
    .COL_W(COL_W), .PAGE_W(PAGE_W), .DLY_W(DLY_W), .READY_BIT(READY_BIT)
  ) u_dp (
    .clk, .rstN, .strb, .usTick, .reqOpcode, .reqHasCol, .reqColumn,
    .reqHasPage, .reqPage, .reqBig, .reqWide16, .reqDelayUs, .statusByte,
    .busData, .hasCol, .hasPage, .isBig, .isNoWait, .isRead, .isReset,
    .dlyZero, .devReady
  );
endmodule

// File: tb/tb_nand_cmd_seq.sv
module tb_nand_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV = 3;

  logic clk = 1'b0, rstN = 1'b0, usTick = 1'b0, reqValid = 1'b0;
  logic [7:0] reqOpcode = '0;
  logic reqHasCol = 1'b0, reqHasPage = 1'b0, reqBig = 1'b0, reqWide16 = 1'b0;
  logic [15:0] reqColumn = '0, reqDelayUs = '0;
  logic [23:0] reqPage = '0;
  logic [7:0] statusByte = 8'hBF;
  logic busy, busValid, busCle, busAle, busCe, busRead, done;
  logic [7:0] busData;

  nand_cmd_seq dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int divCnt = 0;
  always @(posedge clk) begin
    divCnt <= (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    usTick <= (divCnt == TICK_DIV - 1);
  end

  int checks = 0, fails = 0;
  int cyc = 0, evN = 0, readCnt = 0, nrG = 0, lastEvCyc = 0, doneCyc = 0;
  int doneCnt = 0, tickCnt = 0, ticksStat = 0;
  bit relOk = 1'b0;
  logic [7:0] evD [64];
  int evK [64];
  logic [7:0] expD [64];
  int expK [64];
  int expN = 0;

  // Event kinds: 1 = command cycle, 2 = address cycle, 3 = status read
  always @(negedge clk) begin
    cyc++;
    if (usTick) tickCnt++;
    if (cyc == lastEvCyc + 1)
      relOk = busCe && !busCle && !busAle && !busValid;
    if (busValid || busRead) begin
      if (evN < 64) begin
        evD[evN] = busData;
        evK[evN] = busRead ? 3 : (busCle ? 1 : (busAle ? 2 : 0));
      end
      if (busValid && busCle && busData == 8'h70) ticksStat = tickCnt;
      evN++;
      lastEvCyc = cyc;
      tickCnt = 0;
    end
    if (busRead) begin
      readCnt++;
      statusByte = (readCnt > nrG) ? 8'h40 : 8'hBF;
    end else statusByte = 8'hBF;
    if (done) begin
      doneCnt++;
      doneCyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic addExp(input logic [7:0] d, input int k);
    expD[expN] = d; expK[expN] = k; expN++;
  endtask

  task automatic runOp(input logic [7:0] op, input bit hc, input logic [15:0] col,
                       input bit hp, input logic [23:0] pg, input bit big,
                       input bit wide, input int dly, input int nr, input bit spur);
    logic [15:0] ec;
    bit noWait;
    int waitCyc;
    string tagSeq;
    expN = 0;
    ec = wide ? (col >> 1) : col;
    addExp(op, 1);
    if (hc) begin addExp(ec[7:0], 2); addExp(ec[15:8], 2); end
    if (hp) begin
      addExp(pg[7:0], 2); addExp(pg[15:8], 2);
      if (big) addExp(pg[23:16], 2);
    end
    noWait = (op == 8'h60 || op == 8'hD0 || op == 8'h80 || op == 8'h10);
    if (op == 8'h00) addExp(8'h30, 1);
    if (op == 8'hFF) begin
      addExp(8'h70, 1);
      for (int i = 0; i <= nr; i++) addExp(8'h00, 3);
    end
    tagSeq = (op == 8'hFF) ? "R8" : (op == 8'h00) ? "R7" : (hp ? "R4" : (hc ? "R3" : "R2"));

    @(negedge clk);
    evN = 0; readCnt = 0; nrG = nr; doneCnt = 0; lastEvCyc = cyc + 1000000;
    reqOpcode = op; reqHasCol = hc; reqColumn = col; reqHasPage = hp;
    reqPage = pg; reqBig = big; reqWide16 = wide; reqDelayUs = 16'(dly);
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy, "R1", busy, 1);
    if (spur) begin
      @(negedge clk);
      reqOpcode = 8'h90; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    waitCyc = 0;
    while (doneCnt == 0 && waitCyc < 5000) begin
      @(negedge clk);
      waitCyc++;
    end
    chk(doneCnt != 0, "R1 done seen", doneCnt, 1);
    repeat (3) @(negedge clk);
    chk(doneCnt == 1, "R1 done pulse", doneCnt, 1);
    chk(!busy && !busCe, "R10 idle", busCe, 0);
    chk(evN == expN, tagSeq, evN, expN);
    for (int i = 0; i < expN && i < evN; i++) begin
      if (expK[i] != 3) chk(evD[i] == expD[i], tagSeq, evD[i], expD[i]);
      chk(evK[i] == expK[i], tagSeq, evK[i], expK[i]);
    end
    if (noWait) begin
      chk(doneCyc - lastEvCyc == 2, "R6", doneCyc - lastEvCyc, 2);
      chk(relOk, "R5", relOk, 1);
    end else if (op == 8'hFF) begin
      chk(ticksStat >= dly && ticksStat <= dly + 3, "R8 wait", ticksStat, dly);
      chk(readCnt == nr + 1, "R8 polls", readCnt, nr + 1);
    end else begin
      chk(tickCnt >= dly && tickCnt <= dly + 3, op == 8'h00 ? "R7 wait" : "R9 wait",
          tickCnt, dly);
      chk(relOk, "R5", relOk, 1);
    end
  endtask

  initial begin
    int unsigned seed;
    logic [7:0] ops [8];
    seed = 32'd1234;
    void'($urandom(seed));
    ops = '{8'h00, 8'hFF, 8'h60, 8'hD0, 8'h80, 8'h10, 8'h90, 8'hEF};
    repeat (3) @(negedge clk);
    chk(!busy && !done && !busCe && !busValid && !busRead, "R1 reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    // Directed corners
    runOp(8'h60, 1'b0, 16'h0, 1'b1, 24'hABCDEF, 1'b1, 1'b0, 0, 0, 1'b0); // R4 R6
    runOp(8'h60, 1'b0, 16'h0, 1'b1, 24'h123456, 1'b0, 1'b0, 0, 0, 1'b0); // R4
    runOp(8'h80, 1'b1, 16'h1235, 1'b1, 24'h00A5C3, 1'b1, 1'b1, 0, 0, 1'b0); // R3
    runOp(8'h00, 1'b1, 16'hBEEF, 1'b1, 24'h010203, 1'b0, 1'b0, 4, 0, 1'b1); // R7 R1
    runOp(8'hFF, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0, 1'b0, 2, 4, 1'b0); // R8
    runOp(8'hFF, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0, 1'b0, 0, 0, 1'b0); // R8
    runOp(8'h90, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0, 1'b0, 0, 0, 1'b0); // R9 zero wait
    runOp(8'hEF, 1'b1, 16'h0301, 1'b0, 24'h0, 1'b0, 1'b0, 5, 0, 1'b1); // R9
    runOp(8'hD0, 1'b0, 16'h0, 1'b0, 24'h0, 1'b0, 1'b0, 7, 0, 1'b0); // R6 ignores wait
    // Random mix
    for (int n = 0; n < 40; n++)
      runOp(ops[$urandom % 8], 1'($urandom), 16'($urandom), 1'($urandom),
            24'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 6),
            int'($urandom % 5), 1'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule